// File: doc/BRIEF.md
# Micro-Tiled Texel Bit-Address Generator

This block turns a texel coordinate into the bit address of that texel inside a surface. The surface is stored as square micro-tiles of 8x8 elements. A tile is either one element deep (thin) or four elements deep (thick). The caller supplies the surface geometry that was already padded elsewhere: bits per element, padded width and padded height. It also supplies the array slice to address, the byte size of one array slice of the current mip level, and the byte offset at which that level starts. The block adds no padding of its own.

The address is built from four parts:
- the index of the tile inside its slab,
- the index of the slab, where a slab is one tile depth along z,
- a Morton-ordered element index inside the tile,
- the array and level base.

The result is given in bits, so elements narrower than a byte can be addressed. A new request can be accepted on every cycle. There is no backpressure, and a valid flag travels with each request.

Top module: `texel_tile_addr`

## Requirements
- R1: A request presented with `in_valid` high is sampled on a rising edge. Its result appears, with `out_valid` high, after the third rising edge counting the sampling edge. Requests on consecutive cycles give results on consecutive cycles, in the same order.
- R2: While `rst_n` is low, `out_valid` is 0 and `bit_addr` is 0.
- R3: In thin mode (`thick`=0) the element index is 6 bits, with bit 0 = x[0], bit 1 = y[0], bit 2 = x[1], bit 3 = y[1], bit 4 = x[2] and bit 5 = y[2]. Its upper bits are 0.
- R4: In thick mode (`thick`=1) the element index also carries z[1:0] in bits 7:6, and the slab index is z/4. In thin mode the slab index is z.
- R5: The byte size of one tile is ceil(64 × depth × `bpe` / 8), where depth is 4 in thick mode and 1 in thin mode.
- R6: The tile offset in bytes is ((y/8) × (`pad_w`/8) + x/8) × tile bytes.
- R7: Tiles per slab is (`pad_w`/8) × (`pad_h`/8), forced to 1 when that product is 0. The slab offset in bytes is slab index × tiles per slab × tile bytes.
- R8: The term (`level_base` + `array_slice` × `slice_bytes`) × 8 is added to the bit address.
- R9: `bit_addr` = (slab offset + tile offset) × 8 + element index × `bpe` + the base term of R8, computed modulo 2^64.
- R10: When a pipeline slot carries no request, `out_valid` is 0 in the matching output cycle and `bit_addr` keeps the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| thick | input | 1 | 1 = tile depth 4, 0 = tile depth 1 |
| x | input | 14 | Texel column |
| y | input | 14 | Texel row |
| z | input | 14 | Texel depth coordinate |
| bpe | input | 8 | Bits per element |
| pad_w | input | 15 | Padded surface width in elements |
| pad_h | input | 15 | Padded surface height in elements |
| array_slice | input | 11 | Array slice index |
| slice_bytes | input | 32 | Bytes in one array slice of this level |
| level_base | input | 40 | Byte offset at which the level starts |
| out_valid | output | 1 | Result valid |
| bit_addr | output | 64 | Texel bit address |

## Verification
The hardest case to reach is the tiles-per-slab floor. A padded width or height below 8 makes the product zero, and the address is then still expected to advance by one whole tile per slab. The stimulus drives a 4-element-wide surface with nonzero z in both tile depths to reach it. A second awkward case is keeping requests apart while they overlap in the pipeline. Back-to-back requests with different geometry are interleaved with a single idle slot. This shows each result leaving in its own cycle and the idle slot keeping the previous address.

// File: rtl/tta_pkg.sv
package tta_pkg;

    typedef enum logic {
        DEPTH_THIN  = 1'b0,
        DEPTH_THICK = 1'b1
    } tta_depth_e;

    // log2 of the tile depth for the selected mode
    function automatic int unsigned depth_log(input tta_depth_e mode, input int unsigned thick_log);
        return (mode == DEPTH_THICK) ? thick_log : 0;
    endfunction

endpackage

// File: rtl/tta_geom.sv
module tta_geom
    import tta_pkg::*;
#(
    parameter int COORD_W   = 14,
    parameter int BPE_W     = 8,
    parameter int DIM_W     = 15,
    parameter int SLICE_W   = 11,
    parameter int SIZE_W    = 32,
    parameter int LEVEL_W   = 40,
    parameter int ADDR_W    = 64,
    parameter int TILE_LOG  = 3,
    parameter int THICK_LOG = 2,
    localparam int EIDX_W   = 2 * TILE_LOG + THICK_LOG
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_thick,
    input  logic [COORD_W-1:0]   x,
    input  logic [COORD_W-1:0]   y,
    input  logic [COORD_W-1:0]   z,
    input  logic [BPE_W-1:0]     bpe,
    input  logic [DIM_W-1:0]     pad_w,
    input  logic [DIM_W-1:0]     pad_h,
    input  logic [SLICE_W-1:0]   array_slice,
    input  logic [SIZE_W-1:0]    slice_bytes,
    input  logic [LEVEL_W-1:0]   level_base,
    output logic                 s1_valid,
    output logic [ADDR_W-1:0]    s1_tile_idx,
    output logic [ADDR_W-1:0]    s1_tps,
    output logic [ADDR_W-1:0]    s1_slab,
    output logic [ADDR_W-1:0]    s1_tile_bytes,
    output logic [EIDX_W-1:0]    s1_elem,
    output logic [BPE_W-1:0]     s1_bpe,
    output logic [ADDR_W-1:0]    s1_base
);

    // bytes per tile in thin mode is edge^2 * bpe / 8
    localparam int TB_SHIFT = 2 * TILE_LOG - 3;

    typedef struct packed {
        logic              vld;
        logic              thick;
        logic [ADDR_W-1:0] tile_idx;
        logic [ADDR_W-1:0] tps;
        logic [ADDR_W-1:0] slab;
        logic [ADDR_W-1:0] tile_bytes;
        logic [EIDX_W-1:0] elem;
        logic [BPE_W-1:0]  bpe;
        logic [ADDR_W-1:0] base;
    } geom_t;

    geom_t geom_d, geom_q;

    // Morton-ordered element index inside the tile
    logic [EIDX_W-1:0] mort;
    for (genvar g = 0; g < TILE_LOG; g++) begin : g_mort
        assign mort[2*g]   = x[g];
        assign mort[2*g+1] = y[g];
    end
    assign mort[EIDX_W-1 -: THICK_LOG] = in_thick ? z[THICK_LOG-1:0] : '0;

    logic [ADDR_W-1:0] tpr, tps_raw;
    tta_depth_e        mode;

    always_comb begin
        mode    = tta_depth_e'(in_thick);
        tpr     = ADDR_W'(pad_w) >> TILE_LOG;
        tps_raw = tpr * (ADDR_W'(pad_h) >> TILE_LOG);

        geom_d     = geom_q;
        geom_d.vld = in_valid;
        if (in_valid) begin
            geom_d.thick      = in_thick;
            geom_d.tile_idx   = (ADDR_W'(y) >> TILE_LOG) * tpr + (ADDR_W'(x) >> TILE_LOG);
            geom_d.tps        = (tps_raw == '0) ? ADDR_W'(1) : tps_raw;
            geom_d.slab       = ADDR_W'(z) >> depth_log(mode, THICK_LOG);
            geom_d.tile_bytes = ADDR_W'(bpe) << (TB_SHIFT + depth_log(mode, THICK_LOG));
            geom_d.elem       = mort;
            geom_d.bpe        = bpe;
            geom_d.base       = ADDR_W'(level_base) + ADDR_W'(array_slice) * ADDR_W'(slice_bytes);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) geom_q <= '0;
        else        geom_q <= geom_d;
    end

    assign s1_valid      = geom_q.vld;
    assign s1_tile_idx   = geom_q.tile_idx;
    assign s1_tps        = geom_q.tps;
    assign s1_slab       = geom_q.slab;
    assign s1_tile_bytes = geom_q.tile_bytes;
    assign s1_elem       = geom_q.elem;
    assign s1_bpe        = geom_q.bpe;
    assign s1_base       = geom_q.base;

    // R3: a thin request leaves the depth bits of the element index clear
    a_r3_thin_depth_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_thick) |=> (s1_elem[EIDX_W-1 -: THICK_LOG] == '0));

    // R7: tiles per slab never reaches zero
    a_r7_tps_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> (s1_tps != '0));

    // R5: tile size follows bits per element of the same request
    a_r5_tile_bytes_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bpe == '0) |=> (s1_tile_bytes == '0));

endmodule

// File: rtl/tta_combine.sv
module tta_combine #(
    parameter int BPE_W  = 8,
    parameter int ADDR_W = 64,
    parameter int EIDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s1_valid,
    input  logic [ADDR_W-1:0] s1_tile_idx,
    input  logic [ADDR_W-1:0] s1_tps,
    input  logic [ADDR_W-1:0] s1_slab,
    input  logic [ADDR_W-1:0] s1_tile_bytes,
    input  logic [EIDX_W-1:0] s1_elem,
    input  logic [BPE_W-1:0]  s1_bpe,
    input  logic [ADDR_W-1:0] s1_base,
    output logic              s2_valid,
    output logic [ADDR_W-1:0] s2_byte_off,
    output logic [ADDR_W-1:0] s2_elem_bits
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] byte_off;
        logic [ADDR_W-1:0] elem_bits;
    } comb_t;

    comb_t comb_d, comb_q;
    logic [ADDR_W-1:0] tile_count;

    always_comb begin
        tile_count   = s1_slab * s1_tps + s1_tile_idx;
        comb_d       = comb_q;
        comb_d.vld   = s1_valid;
        if (s1_valid) begin
            comb_d.byte_off  = tile_count * s1_tile_bytes + s1_base;
            comb_d.elem_bits = ADDR_W'(s1_elem) * ADDR_W'(s1_bpe);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) comb_q <= '0;
        else        comb_q <= comb_d;
    end

    assign s2_valid     = comb_q.vld;
    assign s2_byte_off  = comb_q.byte_off;
    assign s2_elem_bits = comb_q.elem_bits;

    // R1: every stage-1 request reaches stage 2 on the next edge
    a_r1_stage_follow: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> s2_valid);

endmodule

// File: rtl/texel_tile_addr.sv
module texel_tile_addr #(
    parameter int COORD_W   = 14,
    parameter int BPE_W     = 8,
    parameter int DIM_W     = 15,
    parameter int SLICE_W   = 11,
    parameter int SIZE_W    = 32,
    parameter int LEVEL_W   = 40,
    parameter int ADDR_W    = 64,
    parameter int TILE_LOG  = 3,
    parameter int THICK_LOG = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               thick,
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    input  logic [COORD_W-1:0] z,
    input  logic [BPE_W-1:0]   bpe,
    input  logic [DIM_W-1:0]   pad_w,
    input  logic [DIM_W-1:0]   pad_h,
    input  logic [SLICE_W-1:0] array_slice,
    input  logic [SIZE_W-1:0]  slice_bytes,
    input  logic [LEVEL_W-1:0] level_base,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  bit_addr
);

    localparam int EIDX_W = 2 * TILE_LOG + THICK_LOG;

    logic              s1_valid;
    logic [ADDR_W-1:0] s1_tile_idx, s1_tps, s1_slab, s1_tile_bytes, s1_base;
    logic [EIDX_W-1:0] s1_elem;
    logic [BPE_W-1:0]  s1_bpe;
    logic              s2_valid;
    logic [ADDR_W-1:0] s2_byte_off, s2_elem_bits;

    tta_geom #(
        .COORD_W(COORD_W), .BPE_W(BPE_W), .DIM_W(DIM_W), .SLICE_W(SLICE_W),
        .SIZE_W(SIZE_W), .LEVEL_W(LEVEL_W), .ADDR_W(ADDR_W),
        .TILE_LOG(TILE_LOG), .THICK_LOG(THICK_LOG)
    ) u_geom (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_thick(thick),
        .x(x), .y(y), .z(z), .bpe(bpe), .pad_w(pad_w), .pad_h(pad_h),
        .array_slice(array_slice), .slice_bytes(slice_bytes), .level_base(level_base),
        .s1_valid(s1_valid), .s1_tile_idx(s1_tile_idx), .s1_tps(s1_tps),
        .s1_slab(s1_slab), .s1_tile_bytes(s1_tile_bytes), .s1_elem(s1_elem),
        .s1_bpe(s1_bpe), .s1_base(s1_base)
    );

    tta_combine #(
        .BPE_W(BPE_W), .ADDR_W(ADDR_W), .EIDX_W(EIDX_W)
    ) u_combine (
        .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_tile_idx(s1_tile_idx),
        .s1_tps(s1_tps), .s1_slab(s1_slab), .s1_tile_bytes(s1_tile_bytes),
        .s1_elem(s1_elem), .s1_bpe(s1_bpe), .s1_base(s1_base),
        .s2_valid(s2_valid), .s2_byte_off(s2_byte_off), .s2_elem_bits(s2_elem_bits)
    );

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = s2_valid;
        if (s2_valid) out_d.addr = (s2_byte_off << 3) + s2_elem_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.vld;
    assign bit_addr  = out_q.addr;

    // R1: a stage-2 request is presented on the next edge
    a_r1_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        s2_valid |=> out_valid);

    // R10: an empty slot leaves the address untouched
    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !s2_valid |=> $stable(bit_addr));

    // R9: a presented address is fully defined
    a_r9_no_unknown: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(bit_addr));

endmodule

// File: tb/texel_tile_addr_test.sv
`timescale 1ns/1ps
module texel_tile_addr_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        thick = 1'b0;
    logic [13:0] x = '0, y = '0, z = '0;
    logic [7:0]  bpe = '0;
    logic [14:0] pad_w = '0, pad_h = '0;
    logic [10:0] array_slice = '0;
    logic [31:0] slice_bytes = '0;
    logic [39:0] level_base = '0;
    logic        out_valid;
    logic [63:0] bit_addr;

    int checks = 0;
    int errors = 0;

    logic        hv [3];
    logic [63:0] ha [3];
    string       ht [3];
    logic [63:0] last_a = '0;

    always #2 clk = ~clk;

    texel_tile_addr uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .thick(thick),
        .x(x), .y(y), .z(z), .bpe(bpe), .pad_w(pad_w), .pad_h(pad_h),
        .array_slice(array_slice), .slice_bytes(slice_bytes), .level_base(level_base),
        .out_valid(out_valid), .bit_addr(bit_addr)
    );

    function automatic logic [63:0] model(input logic thk, input logic [13:0] px, py, pz,
                                          input logic [7:0] pb, input logic [14:0] pw, ph,
                                          input logic [10:0] ps, input logic [31:0] psz,
                                          input logic [39:0] plv);
        logic [63:0] dep, tb, tpr, tps, slab_off, tile_off, idx;
        dep = thk ? 64'd4 : 64'd1;
        tb  = (64 * dep * pb + 7) / 8;
        tpr = pw / 8;
        tps = tpr * (ph / 8);
        if (tps == 0) tps = 1;
        slab_off = (pz / dep) * tps * tb;
        tile_off = ((py / 8) * tpr + px / 8) * tb;
        idx = 0;
        for (int i = 0; i < 3; i++) begin
            idx = idx | (64'(px[i]) << (2 * i)) | (64'(py[i]) << (2 * i + 1));
        end
        if (thk) idx = idx | (64'(pz % 4) << 6);
        return (slab_off + tile_off) * 8 + idx * pb + (64'(plv) + 64'(ps) * 64'(psz)) * 8;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [63:0] act, exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (valid %0b) expected %0d", tag, act, out_valid, exp);
        end
    endtask

    // one cycle: check the slot leaving now, then drive the next request
    task automatic push(input logic v, input logic thk, input logic [13:0] px, py, pz,
                        input logic [7:0] pb, input logic [14:0] pw, ph,
                        input logic [10:0] ps, input logic [31:0] psz,
                        input logic [39:0] plv, input string tag);
        @(negedge clk);
        if (hv[2]) begin
            check(out_valid === 1'b1 && bit_addr === ha[2], ht[2], bit_addr, ha[2]);
            last_a = ha[2];
        end else begin
            check(out_valid === 1'b0 && bit_addr === last_a, "R10 idle slot holds", bit_addr, last_a);
        end
        hv[2] = hv[1]; ha[2] = ha[1]; ht[2] = ht[1];
        hv[1] = hv[0]; ha[1] = ha[0]; ht[1] = ht[0];
        in_valid = v; thick = thk; x = px; y = py; z = pz; bpe = pb;
        pad_w = pw; pad_h = ph; array_slice = ps; slice_bytes = psz; level_base = plv;
        hv[0] = v;
        ha[0] = model(thk, px, py, pz, pb, pw, ph, ps, psz, plv);
        ht[0] = tag;
    endtask

    task automatic idle();
        push(1'b0, 1'b0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) idle();
    endtask

    task automatic t_reset();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(out_valid === 1'b0 && bit_addr === 64'd0, "R2 reset state", bit_addr, 64'd0);
        end
        rst_n = 1'b1;
    endtask

    task automatic t_morton();
        push(1, 0, 5, 3, 0, 1, 8, 8, 0, 0, 0, "R3 Morton x=5 y=3");
        flush();
        @(negedge clk);
        check(bit_addr === 64'd27, "R3 Morton literal 27", bit_addr, 64'd27);
        for (int i = 0; i < 8; i++) begin
            push(1, 0, 14'(i), 14'(7 - i), 0, 1, 8, 8, 0, 0, 0, "R3 Morton sweep");
        end
        flush();
    endtask

    task automatic t_thick();
        push(1, 1, 0, 0, 6, 1, 8, 8, 0, 0, 0, "R4 thick z=6");
        flush();
        @(negedge clk);
        check(bit_addr === 64'd384, "R4 thick literal 384", bit_addr, 64'd384);
        for (int i = 0; i < 9; i++) begin
            push(1, 1, 14'(3 + i), 14'(2 * i), 14'(i), 16, 32, 16, 0, 0, 0, "R4 R5 thick sweep");
        end
        flush();
    endtask

    task automatic t_tiles();
        push(1, 0, 0, 0, 0, 32, 64, 64, 0, 0, 0, "R5 origin");
        push(1, 0, 9, 0, 0, 32, 64, 64, 0, 0, 0, "R6 next tile column");
        push(1, 0, 0, 8, 0, 32, 64, 64, 0, 0, 0, "R6 next tile row");
        push(1, 0, 63, 63, 2, 32, 64, 64, 0, 0, 0, "R6 R7 last tile thin slab 2");
        push(1, 0, 100, 37, 5, 8, 128, 48, 0, 0, 0, "R9 general thin");
        flush();
    endtask

    task automatic t_small();
        push(1, 0, 3, 5, 2, 8, 4, 64, 0, 0, 0, "R7 narrow surface thin");
        push(1, 1, 2, 1, 9, 8, 4, 4, 0, 0, 0, "R7 tiny surface thick");
        push(1, 0, 7, 2, 3, 4, 64, 4, 0, 0, 0, "R7 short surface");
        flush();
    endtask

    task automatic t_base();
        push(1, 0, 1, 1, 0, 32, 64, 64, 3, 32'h0001_0000, 40'h12_3456_7800, "R8 slice and level base");
        push(1, 1, 20, 9, 7, 64, 32, 32, 2047, 32'hFFFF_FFF0, 40'hFF_FFFF_FF00, "R8 max base");
        flush();
    endtask

    task automatic t_stream();
        push(1, 0, 10, 20, 1, 32, 64, 64, 0, 0, 0, "R1 stream a");
        push(1, 1, 30, 40, 6, 16, 64, 64, 1, 4096, 256, "R1 stream b");
        idle();
        push(1, 0, 55, 2, 0, 128, 128, 8, 0, 0, 64, "R1 stream c");
        push(1, 1, 0, 15, 13, 2, 16, 16, 5, 2048, 0, "R1 stream d");
        idle();
        idle();
        push(1, 0, 1, 1, 1, 1, 8, 8, 0, 0, 0, "R1 stream e");
        flush();
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            hv[i] = 1'b0; ha[i] = '0; ht[i] = "";
        end
        t_reset();
        t_morton();
        t_thick();
        t_tiles();
        t_small();
        t_base();
        t_stream();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule